// File: doc/BRIEF.md
# Timer Frame Access Controller

This block is the control-frame register file of a memory-mapped system timer that serves up to eight timer frames. Software reaches it over a simple 32-bit register bus. It exposes two kinds of register. A read-only identification word tells software which frames carry a virtual timer. One permission register per frame decides which counter reads and which timer writes that frame allows.

Each frame's permission register holds six bits. A bit that the frame does not implement is tied to zero: it ignores writes and always reads back as zero. Software therefore probes a frame by writing all ones and reading the word back. The current permission bits of every frame leave the block on a packed output vector, and the timer frames use them to gate their own registers. The block also flags, for each frame, whether it currently qualifies as a virtual timer and whether it qualifies as a physical timer.

The number of frames, the set of implemented bits of each frame and each frame's virtual capability are all fixed by parameter.

Top module: `tmr_frame_acl`

## Requirements
- R1: After reset every permission register is zero, `rd_valid` is low and `rdata` is zero.
- R2: A read of byte offset 0x08 returns the identification word. In that word, bit 4*n+1 is set exactly when frame n exists and is virtual-capable, and every other bit is zero. Writes to 0x08 change nothing.
- R3: The permission register of frame n sits at byte offset 0x40 + 4*n. A write to it stores `wdata[5:0]` masked by the frame's implemented-bit mask, and a read of it returns that value with bits 31:6 zero.
- R4: A permission bit that a frame does not implement ignores writes and reads back as zero, so writing all ones reads back as the frame's implemented-bit mask.
- R5: `frame_perm[6*n+5:6*n]` equals frame n's permission register and shows a write on the clock edge that accepts it. The bit meanings are: 0 read physical count, 1 read virtual count, 2 read frequency, 3 read virtual offset, 4 write virtual timer, 5 write physical timer.
- R6: `virt_usable[n]` is high exactly when frame n is virtual-capable and its permission bits 1 and 4 are both set.
- R7: `phys_usable[n]` is high exactly when frame n's permission bits 0 and 5 are both set.
- R8: Reads of any other offset return zero, and writes to them change no register. Such offsets include those that are not word-aligned and the slots of frames beyond the configured count.
- R9: `rd_valid` and `rdata` appear on the edge after `rd_en` is sampled. In every cycle without `rd_valid`, `rdata` is zero.
- R10: When a read and a write to the same register are accepted on the same edge, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Byte offset |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| frame_perm | output | 6*NUM_FRAMES | Packed permission bits, six per frame |
| virt_usable | output | NUM_FRAMES | Frame qualifies as a virtual timer |
| phys_usable | output | NUM_FRAMES | Frame qualifies as a physical timer |

## Verification
The bench writes every one of the 64 six-bit values into every frame of a six-frame configuration whose masks mix full, physical-only, virtual-only and empty frames. One empty frame is flagged virtual-capable. A design that forgot a mask would read back or drive unimplemented bits, and one that ignored the capability flag would mark that empty frame usable. Every offset from 0x00 to 0x7F outside the mapped set is read and written with all ones. A loose decode would then alias a misaligned or out-of-range offset onto a frame and corrupt its permissions. A read issued together with a write must return the old value, which exposes a read path taken from the next-state value.

// File: rtl/tmr_frame_acl_pkg.sv
package tmr_frame_acl_pkg;

    // Width of one frame's permission register.
    localparam int PERM_W = 6;

    // Permission bit positions, decoded by the timer frames.
    localparam int PB_RD_PCOUNT = 0;
    localparam int PB_RD_VCOUNT = 1;
    localparam int PB_RD_FREQ   = 2;
    localparam int PB_RD_VOFF   = 3;
    localparam int PB_WR_VTIMER = 4;
    localparam int PB_WR_PTIMER = 5;

    // Register map (byte offsets).
    localparam int ID_OFFSET   = 'h08;
    localparam int PERM_BASE   = 'h40;
    localparam int PERM_STRIDE = 4;
    localparam int ID_VBIT_STRIDE = 4;
    localparam int ID_VBIT_OFS    = 1;

    localparam int IDX_W = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_ID   = 2'd1,
        SEL_PERM = 2'd2
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

endpackage

// File: rtl/tmr_frame_acl_dec.sv
module tmr_frame_acl_dec
    import tmr_frame_acl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_FRAMES = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    always_comb begin
        dec.sel = SEL_NONE;
        dec.idx = '0;
        if (addr == ADDR_W'(ID_OFFSET)) begin
            dec.sel = SEL_ID;
        end
        for (int n = 0; n < NUM_FRAMES; n++) begin
            if (addr == ADDR_W'(PERM_BASE + PERM_STRIDE * n)) begin
                dec.sel = SEL_PERM;
                dec.idx = IDX_W'(n);
            end
        end
    end

endmodule

// File: rtl/tmr_frame_acl_perm.sv
module tmr_frame_acl_perm
    import tmr_frame_acl_pkg::*;
#(
    parameter logic [PERM_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [PERM_W-1:0] wr_bits,
    output logic [PERM_W-1:0] perm_q
);

    logic [PERM_W-1:0] perm_d;

    always_comb begin
        perm_d = perm_q;
        if (wr_stb) begin
            perm_d = wr_bits & IMPL_MASK;
        end
    end

    for (genvar b = 0; b < PERM_W; b++) begin : g_bit
        if (IMPL_MASK[b]) begin : g_impl
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    perm_q[b] <= 1'b0;
                end else begin
                    perm_q[b] <= perm_d[b];
                end
            end
        end else begin : g_tied
            logic unused_d;
            assign unused_d  = perm_d[b];
            assign perm_q[b] = 1'b0;
        end
    end

endmodule

// File: rtl/tmr_frame_acl_rdmux.sv
module tmr_frame_acl_rdmux
    import tmr_frame_acl_pkg::*;
#(
    parameter int                    DATA_W     = 32,
    parameter int                    NUM_FRAMES = 8,
    parameter logic [NUM_FRAMES-1:0] VIRT_CAP   = '1
) (
    input  dec_t                                dec,
    input  logic [NUM_FRAMES-1:0][PERM_W-1:0]   perm_all,
    output logic [DATA_W-1:0]                   word
);

    function automatic logic [DATA_W-1:0] id_word();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int n = 0; n < NUM_FRAMES; n++) begin
            w[ID_VBIT_STRIDE * n + ID_VBIT_OFS] = VIRT_CAP[n];
        end
        return w;
    endfunction

    localparam logic [DATA_W-1:0] ID_VALUE = id_word();

    always_comb begin
        word = '0;
        unique case (dec.sel)
            SEL_ID: word = ID_VALUE;
            SEL_PERM: begin
                for (int n = 0; n < NUM_FRAMES; n++) begin
                    if (dec.idx == IDX_W'(n)) begin
                        word = {{(DATA_W-PERM_W){1'b0}}, perm_all[n]};
                    end
                end
            end
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/tmr_frame_acl.sv
module tmr_frame_acl
    import tmr_frame_acl_pkg::*;
#(
    parameter int                           ADDR_W     = 8,
    parameter int                           DATA_W     = 32,
    parameter int                           NUM_FRAMES = 8,
    parameter logic [NUM_FRAMES*PERM_W-1:0] IMPL_MASK  = '1,
    parameter logic [NUM_FRAMES-1:0]        VIRT_CAP   = '1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic                         rd_valid,
    output logic [NUM_FRAMES*PERM_W-1:0] frame_perm,
    output logic [NUM_FRAMES-1:0]        virt_usable,
    output logic [NUM_FRAMES-1:0]        phys_usable
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rd_state_t;

    dec_t                              dec;
    logic [NUM_FRAMES-1:0][PERM_W-1:0] perm_all;
    logic [DATA_W-1:0]                 mux_word;
    rd_state_t                         rd_d, rd_q;
    logic                              unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[DATA_W-1:PERM_W];

    tmr_frame_acl_dec #(
        .ADDR_W     (ADDR_W),
        .NUM_FRAMES (NUM_FRAMES)
    ) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_frame
        logic wr_stb;
        assign wr_stb = wr_en && (dec.sel == SEL_PERM) && (dec.idx == IDX_W'(n));

        tmr_frame_acl_perm #(
            .IMPL_MASK (IMPL_MASK[n*PERM_W +: PERM_W])
        ) u_perm (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_stb  (wr_stb),
            .wr_bits (wdata[PERM_W-1:0]),
            .perm_q  (perm_all[n])
        );

        assign virt_usable[n] = VIRT_CAP[n]
                              && perm_all[n][PB_RD_VCOUNT]
                              && perm_all[n][PB_WR_VTIMER];
        assign phys_usable[n] = perm_all[n][PB_RD_PCOUNT]
                              && perm_all[n][PB_WR_PTIMER];
    end

    tmr_frame_acl_rdmux #(
        .DATA_W     (DATA_W),
        .NUM_FRAMES (NUM_FRAMES),
        .VIRT_CAP   (VIRT_CAP)
    ) u_rdmux (
        .dec      (dec),
        .perm_all (perm_all),
        .word     (mux_word)
    );

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = rd_en;
        rd_d.rdata  = rd_en ? mux_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata      = rd_q.rdata;
    assign rd_valid   = rd_q.rvalid;
    assign frame_perm = perm_all;

endmodule

// File: rtl/tmr_frame_acl_chk.sv
module tmr_frame_acl_chk
    import tmr_frame_acl_pkg::*;
#(
    parameter int                           ADDR_W     = 8,
    parameter int                           DATA_W     = 32,
    parameter int                           NUM_FRAMES = 8,
    parameter logic [NUM_FRAMES*PERM_W-1:0] IMPL_MASK  = '1,
    parameter logic [NUM_FRAMES-1:0]        VIRT_CAP   = '1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic                         rd_en,
    input logic [ADDR_W-1:0]            addr,
    input logic [DATA_W-1:0]            wdata,
    input logic [DATA_W-1:0]            rdata,
    input logic                         rd_valid,
    input logic [NUM_FRAMES*PERM_W-1:0] frame_perm,
    input logic [NUM_FRAMES-1:0]        virt_usable,
    input logic [NUM_FRAMES-1:0]        phys_usable
);

    function automatic logic [DATA_W-1:0] exp_id();
        logic [DATA_W-1:0] w;
        w = '0;
        for (int n = 0; n < NUM_FRAMES; n++) begin
            if (VIRT_CAP[n]) w[4*n+1] = 1'b1;
        end
        return w;
    endfunction

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (frame_perm == '0 && !rd_valid && rdata == '0));

    assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(8)) |=> (rdata == exp_id()));

    assert_misaligned_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[1:0] != 2'b00) |=> $stable(frame_perm));

    assert_no_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(frame_perm));

    assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    assert_idle_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rdata == '0));

    for (genvar n = 0; n < NUM_FRAMES; n++) begin : g_fr
        localparam logic [PERM_W-1:0] M = IMPL_MASK[n*PERM_W +: PERM_W];

        assert_perm_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'('h40 + 4*n))
            |=> (frame_perm[n*PERM_W +: PERM_W] == ($past(wdata[PERM_W-1:0]) & M)));

        assert_virt_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'('h40 + 4*n) && wdata[1] && wdata[4]
             && M[1] && M[4] && VIRT_CAP[n]) |=> virt_usable[n]);

        assert_virt_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'('h40 + 4*n) && !wdata[4]) |=> !virt_usable[n]);

        assert_phys_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'('h40 + 4*n) && wdata[0] && wdata[5]
             && M[0] && M[5]) |=> phys_usable[n]);

        assert_phys_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'('h40 + 4*n) && !wdata[0]) |=> !phys_usable[n]);
    end

endmodule

bind tmr_frame_acl tmr_frame_acl_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_FRAMES (NUM_FRAMES),
    .IMPL_MASK  (IMPL_MASK),
    .VIRT_CAP   (VIRT_CAP)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .rd_valid    (rd_valid),
    .frame_perm  (frame_perm),
    .virt_usable (virt_usable),
    .phys_usable (phys_usable)
);

// File: tb/sim_tmr_frame_acl.sv
`timescale 1ns/1ps
module sim_tmr_frame_acl;

    localparam int NF = 6;
    localparam logic [NF*6-1:0] MASKS = {6'h12, 6'h3F, 6'h00, 6'h16, 6'h25, 6'h3F};
    localparam logic [NF-1:0]   VCAP  = 6'b101101;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [7:0]       addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic             rd_valid;
    logic [NF*6-1:0]  frame_perm;
    logic [NF-1:0]    virt_usable;
    logic [NF-1:0]    phys_usable;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [5:0] model [NF];

    always #2.5 clk = ~clk;

    tmr_frame_acl #(
        .ADDR_W     (8),
        .DATA_W     (32),
        .NUM_FRAMES (NF),
        .IMPL_MASK  (MASKS),
        .VIRT_CAP   (VCAP)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .rd_valid    (rd_valid),
        .frame_perm  (frame_perm),
        .virt_usable (virt_usable),
        .phys_usable (phys_usable)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_id();
        logic [31:0] w = '0;
        for (int n = 0; n < NF; n++) w[4*n+1] = VCAP[n];
        return w;
    endfunction

    function automatic logic [NF*6-1:0] exp_vec();
        logic [NF*6-1:0] v;
        for (int n = 0; n < NF; n++) v[n*6 +: 6] = model[n];
        return v;
    endfunction

    function automatic logic [NF-1:0] exp_virt();
        logic [NF-1:0] v;
        for (int n = 0; n < NF; n++) v[n] = VCAP[n] & model[n][1] & model[n][4];
        return v;
    endfunction

    function automatic logic [NF-1:0] exp_phys();
        logic [NF-1:0] v;
        for (int n = 0; n < NF; n++) v[n] = model[n][0] & model[n][5];
        return v;
    endfunction

    function automatic bit is_mapped(input int a);
        if (a == 'h08) return 1'b1;
        for (int n = 0; n < NF; n++) if (a == 'h40 + 4*n) return 1'b1;
        return 1'b0;
    endfunction

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int n = 0; n < NF; n++)
            if (a == 8'('h40 + 4*n)) model[n] = d[5:0] & MASKS[n*6 +: 6];
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rd_valid;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        v;
        for (int n = 0; n < NF; n++) model[n] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 perm", 64'(frame_perm), 64'(0));
        check("R1 rd_valid", 64'(rd_valid), 64'(0));
        check("R1 rdata", 64'(rdata), 64'(0));

        // R2: identification word, then write attempt ignored
        do_read(8'h08, d, v);
        check("R2 id", 64'(d), 64'(exp_id()));
        check("R9 valid", 64'(v), 64'(1));
        do_write(8'h08, 32'hFFFF_FFFF);
        check("R2 write ignored perm", 64'(frame_perm), 64'(exp_vec()));
        do_read(8'h08, d, v);
        check("R2 id after write", 64'(d), 64'(exp_id()));

        // R9: valid drops and data clears in the idle cycle after a read
        @(negedge clk);
        check("R9 idle valid", 64'(rd_valid), 64'(0));
        check("R9 idle rdata", 64'(rdata), 64'(0));

        // R4: capability probe by writing all ones
        for (int f = 0; f < NF; f++) begin
            do_write(8'('h40 + 4*f), 32'hFFFF_FFFF);
            do_read(8'('h40 + 4*f), d, v);
            check("R4 probe", 64'(d), 64'(MASKS[f*6 +: 6]));
        end

        // R3 R5 R6 R7: every value into every frame
        for (int f = 0; f < NF; f++) begin
            for (int val = 0; val < 64; val++) begin
                do_write(8'('h40 + 4*f), {~26'(val * 3), 6'(val)});
                check("R5 perm vector", 64'(frame_perm), 64'(exp_vec()));
                check("R6 virt usable", 64'(virt_usable), 64'(exp_virt()));
                check("R7 phys usable", 64'(phys_usable), 64'(exp_phys()));
                do_read(8'('h40 + 4*f), d, v);
                check("R3 readback", 64'(d), 64'(6'(val) & MASKS[f*6 +: 6]));
            end
        end

        // R8: clear all, then hit every unmapped offset with ones
        for (int f = 0; f < NF; f++) do_write(8'('h40 + 4*f), 32'h0);
        for (int a = 0; a < 128; a++) begin
            if (!is_mapped(a)) begin
                do_read(8'(a), d, v);
                check("R8 unmapped read", 64'(d), 64'(0));
                do_write(8'(a), 32'hFFFF_FFFF);
                check("R8 unmapped write", 64'(frame_perm), 64'(0));
            end
        end

        // R10: read and write on the same edge return the old value
        do_write(8'h40, 32'h0000_0015);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = 8'h40; wdata = 32'h0000_002A;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        model[0] = 6'h2A;
        check("R10 old value", 64'(rdata), 64'(32'h15));
        do_read(8'h40, d, v);
        check("R10 new value", 64'(d), 64'(32'h2A));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule